// File: doc/BRIEF.md
# Monitor Lock Fast Path

This block runs the common, uncontended cases of three monitor instructions (enter, re-enter and exit) directly against a lock word held in memory. A caller presents an opcode and the lock word's address for one cycle. The block then reads the lock word through its own memory port and decides whether the fast case applies. If it does, the block writes the new lock value and reports the operand stack depth the instruction leaves behind. If it does not, the block raises a trap that hands the instruction to a software handler. The trap carries the number of operands the handler receives, and the stack is left empty.

The lock word encodes three situations. The value with only the top bit set means the monitor is free. Zero means the monitor is held and nobody waits for it. Any other value means there is queue state that only software may touch. Re-enter first consults a global flag word at a fixed address. A nonzero flag sends the instruction to software at once. A zero flag makes re-enter behave exactly like enter.

The read of the lock word and the write that follows it form one indivisible pair. A lock output stays high across both accesses so that the memory side admits no other request in between.

Top module: `mlk_fastpath`

## Requirements
- R1: After reset, busy, done, trap, mem_req and mem_lock are all low, and res_depth and trap_nops read 0.
- R2: Opcode 0 (enter) reads the lock word. If the word equals 0x8000, the block writes 0x0000 to the same address and completes with done, res_depth = 1 and trap_nops = 0.
- R3: Enter on any lock value other than 0x8000 completes with trap, trap_nops = 1 and res_depth = 0, and leaves the lock word unwritten.
- R4: Opcode 1 (exit) reads the lock word. If the word equals 0x0000, the block writes 0x8000 and completes with done and res_depth = 0.
- R5: Exit on any lock value other than 0x0000 completes with trap, trap_nops = 1 and res_depth = 0, and leaves the lock word unwritten.
- R6: Opcode 2 (re-enter) first reads the flag word at address HARD_ADDR. If the flag is nonzero, the block completes with trap, trap_nops = 2 and res_depth = 0, and neither reads nor writes the lock word.
- R7: For re-enter with a zero flag, the lock word is then read and handled exactly as in R2 and R3.
- R8: Opcode 3 is not a valid operation. It completes with trap, trap_nops = 0 and res_depth = 0, and makes no memory access.
- R9: busy is high from the cycle after a request is accepted up to and including the completion cycle, and low in the cycle after that. Exactly one of done or trap is high, and only for that single completion cycle.
- R10: A request presented while busy is high is ignored and starts no later operation.
- R11: mem_lock stays high continuously from the lock-word read until the lock-word write has been acknowledged. Every write is issued with mem_lock high, and a pending access keeps its address stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, accepted only while idle |
| req_op | input | 2 | 0 enter, 1 exit, 2 re-enter, 3 invalid |
| req_addr | input | AW | Address of the lock word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: fast path completed |
| trap | output | 1 | One-cycle pulse: hand operation to software |
| res_depth | output | 2 | Operand stack depth left behind, valid with done or trap |
| trap_nops | output | 2 | Operand count for the software handler, valid with trap |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_lock | output | 1 | Keep the memory reserved for this read-modify-write |
| mem_addr | output | AW | Access address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access acknowledge |

## Verification
A wrong state in the sequencer appears at the memory port before it reaches the result pins. A misrouted re-enter shows up as an unexpected read at the flag or lock address. A wrong verdict shows up as a write where none belongs, or as the wrong value written, within two cycles of the lock read being acknowledged. The bench therefore counts every access per address and checks the lock word afterwards, in addition to the done, trap, depth and operand count. A sequencer stuck outside idle keeps busy high past the completion pulse. That is caught one cycle after completion.

// File: rtl/mlk_pkg.sv
package mlk_pkg;

    typedef enum logic [1:0] {
        OP_ENTER   = 2'd0,
        OP_EXIT    = 2'd1,
        OP_REENTER = 2'd2,
        OP_BAD     = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FLAG  = 3'd1,
        ST_LRD   = 3'd2,
        ST_LWR   = 3'd3,
        ST_RESP  = 3'd4
    } state_e;

    typedef struct packed {
        logic       trap;
        logic [1:0] depth;
        logic [1:0] nops;
    } outcome_t;

    localparam logic [1:0] NOPS_NONE    = 2'd0;
    localparam logic [1:0] NOPS_LOCK    = 2'd1;
    localparam logic [1:0] NOPS_REENTER = 2'd2;

    function automatic logic acquires(input op_e op);
        return (op == OP_ENTER) || (op == OP_REENTER);
    endfunction

    function automatic outcome_t trap_with(input logic [1:0] n);
        outcome_t o;
        o.trap  = 1'b1;
        o.depth = 2'd0;
        o.nops  = n;
        return o;
    endfunction

endpackage

// File: rtl/mlk_judge.sv
module mlk_judge
    import mlk_pkg::*;
#(
    parameter int DW = 16
) (
    input  op_e           op_i,
    input  logic [DW-1:0] word_i,
    output logic          fast_o,
    output logic [DW-1:0] word_o,
    output logic [1:0]    depth_o
);
    localparam logic [DW-1:0] FREE_WORD = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] HELD_WORD = '0;

    always_comb begin
        fast_o  = 1'b0;
        word_o  = word_i;
        depth_o = 2'd0;
        if (acquires(op_i)) begin
            fast_o  = (word_i == FREE_WORD);
            word_o  = HELD_WORD;
            depth_o = 2'd1;
        end else if (op_i == OP_EXIT) begin
            fast_o  = (word_i == HELD_WORD);
            word_o  = FREE_WORD;
            depth_o = 2'd0;
        end
    end
endmodule

// File: rtl/mlk_seq.sv
module mlk_seq
    import mlk_pkg::*;
#(
    parameter int              AW        = 16,
    parameter int              DW        = 16,
    parameter logic [AW-1:0]   HARD_ADDR = '1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  op_e           req_op,
    input  logic [AW-1:0] req_addr,
    output op_e           op_q,
    input  logic          j_fast,
    input  logic [DW-1:0] j_word,
    input  logic [1:0]    j_depth,
    output logic          busy,
    output logic          done,
    output logic          trap,
    output logic [1:0]    res_depth,
    output logic [1:0]    trap_nops,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_lock,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack
);
    state_e        state;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    outcome_t      res_q;
    logic          finishing;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            op_q    <= OP_ENTER;
            addr_q  <= '0;
            wdata_q <= '0;
            res_q   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        op_q   <= req_op;
                        addr_q <= req_addr;
                        if (req_op == OP_BAD) begin
                            res_q <= trap_with(NOPS_NONE);
                            state <= ST_RESP;
                        end else if (req_op == OP_REENTER) begin
                            state <= ST_FLAG;
                        end else begin
                            state <= ST_LRD;
                        end
                    end
                end
                ST_FLAG: begin
                    if (mem_ack) begin
                        if (mem_rdata != '0) begin
                            res_q <= trap_with(NOPS_REENTER);
                            state <= ST_RESP;
                        end else begin
                            state <= ST_LRD;
                        end
                    end
                end
                ST_LRD: begin
                    if (mem_ack) begin
                        if (j_fast) begin
                            wdata_q     <= j_word;
                            res_q.trap  <= 1'b0;
                            res_q.depth <= j_depth;
                            res_q.nops  <= NOPS_NONE;
                            state       <= ST_LWR;
                        end else begin
                            res_q <= trap_with(NOPS_LOCK);
                            state <= ST_RESP;
                        end
                    end
                end
                ST_LWR: begin
                    if (mem_ack) begin
                        state <= ST_RESP;
                    end
                end
                ST_RESP: begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign finishing = (state == ST_RESP);
    assign busy      = (state != ST_IDLE);
    assign done      = finishing && !res_q.trap;
    assign trap      = finishing && res_q.trap;
    assign res_depth = finishing ? res_q.depth : 2'd0;
    assign trap_nops = finishing ? res_q.nops  : 2'd0;

    assign mem_req   = (state == ST_FLAG) || (state == ST_LRD) || (state == ST_LWR);
    assign mem_we    = (state == ST_LWR);
    assign mem_lock  = (state == ST_LRD) || (state == ST_LWR);
    assign mem_addr  = (state == ST_FLAG) ? HARD_ADDR : addr_q;
    assign mem_wdata = wdata_q;
endmodule

// File: rtl/mlk_fastpath.sv
module mlk_fastpath
    import mlk_pkg::*;
#(
    parameter int            AW        = 16,
    parameter int            DW        = 16,
    parameter logic [AW-1:0] HARD_ADDR = 16'h000F
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    output logic          busy,
    output logic          done,
    output logic          trap,
    output logic [1:0]    res_depth,
    output logic [1:0]    trap_nops,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_lock,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack
);
    op_e           op_q;
    logic          j_fast;
    logic [DW-1:0] j_word;
    logic [1:0]    j_depth;

    mlk_judge #(.DW(DW)) u_judge (
        .op_i    (op_q),
        .word_i  (mem_rdata),
        .fast_o  (j_fast),
        .word_o  (j_word),
        .depth_o (j_depth)
    );

    mlk_seq #(.AW(AW), .DW(DW), .HARD_ADDR(HARD_ADDR)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_op    (op_e'(req_op)),
        .req_addr  (req_addr),
        .op_q      (op_q),
        .j_fast    (j_fast),
        .j_word    (j_word),
        .j_depth   (j_depth),
        .busy      (busy),
        .done      (done),
        .trap      (trap),
        .res_depth (res_depth),
        .trap_nops (trap_nops),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_lock  (mem_lock),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack)
    );
endmodule

// File: rtl/mlk_fastpath_chk.sv
module mlk_fastpath_chk #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          done,
    input logic          trap,
    input logic [1:0]    res_depth,
    input logic [1:0]    trap_nops,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_lock,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_ack
);
    localparam logic [DW-1:0] FREE_WORD = {1'b1, {(DW-1){1'b0}}};

    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(done && trap));

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && !trap);

    a_r9_trap_single: assert property (@(posedge clk) disable iff (rst)
        trap |=> !done && !trap);

    a_r9_busy_at_end: assert property (@(posedge clk) disable iff (rst)
        (done || trap) |-> busy);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req && !mem_lock && !done && !trap);

    a_r11_write_locked: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> mem_lock);

    a_r11_hold_pending: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    a_r11_lock_release: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_lock) |-> !mem_req);

    a_r2_write_value: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_wdata == '0 || mem_wdata == FREE_WORD));

    a_r3_trap_empty_stack: assert property (@(posedge clk) disable iff (rst)
        trap |-> res_depth == 2'd0);

    a_r6_nops_range: assert property (@(posedge clk) disable iff (rst)
        trap |-> trap_nops != 2'd3);

    a_r2_done_no_nops: assert property (@(posedge clk) disable iff (rst)
        done |-> trap_nops == 2'd0);
endmodule

bind mlk_fastpath mlk_fastpath_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .trap      (trap),
    .res_depth (res_depth),
    .trap_nops (trap_nops),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_lock  (mem_lock),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack)
);

// File: tb/mlk_fastpath_test.sv
`timescale 1ns/1ps
module mlk_fastpath_test;
    localparam logic [15:0] HARD = 16'h000F;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [15:0] req_addr = 16'd0;
    logic        busy, done, trap, mem_req, mem_we, mem_lock, mem_ack;
    logic [1:0]  res_depth, trap_nops;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    mlk_fastpath #(.AW(16), .DW(16), .HARD_ADDR(HARD)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .busy(busy), .done(done), .trap(trap),
        .res_depth(res_depth), .trap_nops(trap_nops), .mem_req(mem_req),
        .mem_we(mem_we), .mem_lock(mem_lock), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    // memory model: one-cycle acknowledge, counts accesses per address
    logic [15:0] mem [16];
    logic [15:0] watch_addr;
    int lock_acc, flag_acc, other_acc, unlocked_wr;

    always @(posedge clk) begin
        if (rst) begin
            mem_ack   <= 1'b0;
            mem_rdata <= 16'd0;
        end else if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem[mem_addr[3:0]];
            if (mem_we) begin
                mem[mem_addr[3:0]] <= mem_wdata;
                if (!mem_lock) unlocked_wr <= unlocked_wr + 1;
            end
            if (mem_addr == watch_addr)      lock_acc  <= lock_acc + 1;
            else if (mem_addr == HARD)       flag_acc  <= flag_acc + 1;
            else                             other_acc <= other_acc + 1;
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic check(input logic ok, input string tag, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [3:0] r);
        case (r)
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            default: return "R8";
        endcase
    endfunction

    typedef struct packed {
        logic [1:0]  op;
        logic [15:0] lock0;
        logic [15:0] flag0;
        logic        x_trap;
        logic [1:0]  x_depth;
        logic [1:0]  x_nops;
        logic [15:0] x_lock;
        logic [3:0]  x_lacc;
        logic [3:0]  x_facc;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 16'h8000, 16'h0007, 1'b0, 2'd1, 2'd0, 16'h0000, 4'd2, 4'd0, 4'd2},
        '{2'd0, 16'h0000, 16'h0000, 1'b1, 2'd0, 2'd1, 16'h0000, 4'd1, 4'd0, 4'd3},
        '{2'd0, 16'h1234, 16'h0000, 1'b1, 2'd0, 2'd1, 16'h1234, 4'd1, 4'd0, 4'd3},
        '{2'd1, 16'h0000, 16'h0007, 1'b0, 2'd0, 2'd0, 16'h8000, 4'd2, 4'd0, 4'd4},
        '{2'd1, 16'h8000, 16'h0000, 1'b1, 2'd0, 2'd1, 16'h8000, 4'd1, 4'd0, 4'd5},
        '{2'd1, 16'h0005, 16'h0000, 1'b1, 2'd0, 2'd1, 16'h0005, 4'd1, 4'd0, 4'd5},
        '{2'd2, 16'h8000, 16'h0000, 1'b0, 2'd1, 2'd0, 16'h0000, 4'd2, 4'd1, 4'd7},
        '{2'd2, 16'h0000, 16'h0000, 1'b1, 2'd0, 2'd1, 16'h0000, 4'd1, 4'd1, 4'd7},
        '{2'd2, 16'h8000, 16'h0001, 1'b1, 2'd0, 2'd2, 16'h8000, 4'd0, 4'd1, 4'd6},
        '{2'd3, 16'h8000, 16'h0000, 1'b1, 2'd0, 2'd0, 16'h8000, 4'd0, 4'd0, 4'd8}
    };

    logic got_trap, got_done, busy_ok, after_ok, timed_out;
    logic [1:0] got_depth, got_nops;

    // issue one request and wait for its completion pulse
    task automatic run_op(input logic [1:0] op, input logic [15:0] addr);
        @(negedge clk);
        req_valid  = 1'b1;
        req_op     = op;
        req_addr   = addr;
        watch_addr <= addr;
        lock_acc   <= 0;
        flag_acc   <= 0;
        other_acc  <= 0;
        @(negedge clk);
        req_valid = 1'b0;
        busy_ok   = 1'b1;
        timed_out = 1'b1;
        for (int n = 0; n < 60; n++) begin
            if (!busy) busy_ok = 1'b0;
            if (done || trap) begin
                timed_out = 1'b0;
                break;
            end
            @(negedge clk);
        end
        got_trap  = trap;
        got_done  = done;
        got_depth = res_depth;
        got_nops  = trap_nops;
        @(negedge clk);
        after_ok = !busy && !done && !trap;
    endtask

    initial begin
        watch_addr  = 16'hFFFF;
        lock_acc    = 0;
        flag_acc    = 0;
        other_acc   = 0;
        unlocked_wr = 0;
        for (int i = 0; i < 16; i++) mem[i] = 16'h0000;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(!busy && !done && !trap, "R1", "busy/done/trap",
              {busy, done, trap}, 0);
        check(!mem_req && !mem_lock, "R1", "mem_req/mem_lock",
              {mem_req, mem_lock}, 0);
        check(res_depth == 0 && trap_nops == 0, "R1", "depth/nops",
              {res_depth, trap_nops}, 0);

        // table of vectors
        for (int i = 0; i < NV; i++) begin
            logic [15:0] la;
            string t;
            la = 16'(i + 1);
            t  = tag_of(VECS[i].rq);
            @(negedge clk);
            mem[la[3:0]] <= VECS[i].lock0;
            mem[HARD[3:0]] <= VECS[i].flag0;
            run_op(VECS[i].op, la);
            check(!timed_out, t, "completion seen", timed_out, 0);
            check(got_trap == VECS[i].x_trap && got_done == !VECS[i].x_trap,
                  t, "trap/done", {got_trap, got_done},
                  {VECS[i].x_trap, !VECS[i].x_trap});
            check(got_depth == VECS[i].x_depth, t, "res_depth",
                  got_depth, VECS[i].x_depth);
            check(got_nops == VECS[i].x_nops, t, "trap_nops",
                  got_nops, VECS[i].x_nops);
            check(mem[la[3:0]] == VECS[i].x_lock, t, "lock word",
                  mem[la[3:0]], VECS[i].x_lock);
            check(lock_acc == int'(VECS[i].x_lacc), t, "lock accesses",
                  lock_acc, VECS[i].x_lacc);
            check(flag_acc == int'(VECS[i].x_facc), t, "flag accesses",
                  flag_acc, VECS[i].x_facc);
            check(mem[HARD[3:0]] == VECS[i].flag0, t, "flag untouched",
                  mem[HARD[3:0]], VECS[i].flag0);
            // R9: busy held through completion, single pulse, idle after
            check(busy_ok, "R9", "busy held", busy_ok, 1);
            check(after_ok, "R9", "idle after pulse", after_ok, 1);
        end

        // R10: requests while busy are ignored
        @(negedge clk);
        mem[2] <= 16'h8000;
        mem[4] <= 16'h8000;
        watch_addr <= 16'h0002;
        lock_acc   <= 0;
        other_acc  <= 0;
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd0; req_addr = 16'h0002;
        @(negedge clk);
        req_op = 2'd1; req_addr = 16'h0004;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        timed_out = 1'b1;
        for (int n = 0; n < 60; n++) begin
            if (done || trap) begin
                timed_out = 1'b0;
                break;
            end
            @(negedge clk);
        end
        check(!timed_out && done, "R10", "first op done", done, 1);
        repeat (4) @(negedge clk);
        check(!busy, "R10", "no second op", busy, 0);
        check(mem[2] == 16'h0000, "R10", "first lock", mem[2], 16'h0000);
        check(mem[4] == 16'h8000, "R10", "ignored lock", mem[4], 16'h8000);
        check(other_acc == 0, "R10", "stray accesses", other_acc, 0);

        // R11: no write was ever issued without the lock held
        check(unlocked_wr == 0, "R11", "writes without lock", unlocked_wr, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule